// File: doc/BRIEF.md
# Keyed Configuration Item Read Port

This block lets a host read a fixed set of configuration items one small access at a time. Each item is a byte string held in an internal read-only table. The host first writes a 16-bit key to the selector. That write picks an item and moves a byte cursor back to the start of it. Each following data read returns the next 1 to `MAX_W` bytes of the item and moves the cursor forward by the number of bytes actually taken.

The bytes of one read are packed as a string. The earliest byte sits in the most significant byte lane of the access, and every lane above the access is zero. When the item runs out before the access is filled, the lowest lanes are filled with zeros and the cursor stays at the end of the item.

The key carries two fields. One bit picks one of two entry tables, and an index field picks an entry inside that table. Index values at or above a fixed limit select nothing, and every read then returns zero.

A parameter chooses between two decodes:
- The split decode has a separate selector window and data window.
- The combined decode shares one narrow window. A 2-byte write there goes to the selector, and a 1-byte access goes to the data path.

Every access gets exactly one response, one cycle later.

Top module: `cfg_item_port`

## Requirements
- R1: After reset, or after a later reset, the selection is table 0 index 0 with the cursor at zero. That item is the 4-byte signature `SIG`, sent most significant byte first, so a 4-byte read returns `SIG`.
- R2: An accepted selector write sets the cursor to zero. This holds for a valid key, an invalid key, and a key equal to the current one.
- R3: Key bit 14 picks table 1 when set. Key bits 13:0 are the index. Key bit 15 is ignored. An index is valid when it is below `FILE_FIRST + FILE_SLOTS` (default 36).
- R4: After an invalid key has been selected, every data read returns zero and is not an error.
- R5: A read of N bytes places item byte `cursor+k` in bits `8*(N-1-k)+7 : 8*(N-1-k)`. All bits at or above `8*N` are zero, and the cursor advances by N when the item has at least N bytes left.
- R6: When fewer than N bytes remain, the missing low lanes are zero and the cursor stops at the item length. Further reads return zero.
- R7: An entry of length zero reads as zero, exactly like an invalid key.
- R8: Table 0 index 1 is the 4-byte version item. Its bytes are {`8'h01 | DMA_PRESENT<<1`, 0, 0, 0}, giving 0x03 in the first byte by default.
- R9: Every other entry has length `(idx + (table ? 3 : 0)) % 7`. Its byte at offset `o` is `{idx[3:0], o[3:0]} ^ (table ? 8'h5A : 8'h00)`.
- R10: The split decode treats window 0 as the selector and window 1 as the data window.
  - The selector takes only 2-byte writes.
  - The data window takes reads of 1 to `MAX_W` bytes at offset 0 only.
  - A data write is accepted and has no effect.
  - Any other access returns an error with zero data and leaves the state unchanged.
- R11: The combined decode ignores the window and the offset.
  - A 1-byte read is a data read.
  - A 1-byte write is accepted and ignored.
  - A 2-byte write is a selector write.
  - Any other access is an error.
- R12: `rsp_valid_o` is high in the cycle after each accepted access and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_i | input | 1 | Access strobe, one cycle per access |
| acc_we_i | input | 1 | 1 = write, 0 = read |
| acc_win_i | input | 1 | Window: 0 selector, 1 data (split decode only) |
| acc_off_i | input | OFF_W | Byte offset inside the window |
| acc_size_i | input | SZ_W | Access size in bytes |
| acc_wdata_i | input | 16 | Write data; the key on a selector write |
| rsp_valid_o | output | 1 | Response valid |
| rsp_err_o | output | 1 | Access not accepted |
| rsp_data_o | output | 8*MAX_W | Read data, right-aligned to the access size |

## Verification
The hardest states to reach from the ports are the partial end of an item and the selector state that follows a rejected access. Neither one shows on an output until a later read.

The stimulus picks item lengths that are not multiples of the access size. It then reads across the end with sizes of 3, 2 and 2 bytes, which exposes both the zero padding and the cursor stopping at the end.

For rejected accesses, the stimulus first drains an item. It then issues a rejected selector write and follows it with a read. Because the item was already drained, a rewind that should not have happened would show up as non-zero data.

// File: rtl/cfg_item_pkg.sv
package cfg_item_pkg;
  localparam int KEY_W    = 16;
  localparam int IDX_W    = 14;
  localparam int TBL_BIT  = 14;
  typedef enum logic [2:0] {OP_NONE, OP_SEL, OP_READ, OP_DROP, OP_BAD} op_e;
endpackage

// File: rtl/cfg_item_decode.sv
module cfg_item_decode
  import cfg_item_pkg::*;
#(
  parameter int MAX_W    = 8,
  parameter int OFF_W    = 3,
  parameter int SZ_W     = 4,
  parameter bit COMBINED = 1'b0
) (
  input  logic             acc_i,
  input  logic             we_i,
  input  logic             win_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [SZ_W-1:0]  size_i,
  output op_e              op_o
);
  generate
    if (COMBINED) begin : g_comb
      logic unused;
      assign unused = win_i ^ (|off_i);
      always_comb begin
        op_o = OP_NONE;
        if (acc_i) begin
          if (we_i && size_i == SZ_W'(1))       op_o = OP_DROP;
          else if (we_i && size_i == SZ_W'(2))  op_o = OP_SEL;
          else if (!we_i && size_i == SZ_W'(1)) op_o = OP_READ;
          else                                  op_o = OP_BAD;
        end
      end
    end else begin : g_split
      always_comb begin
        op_o = OP_NONE;
        if (acc_i) begin
          if (!win_i) begin
            op_o = (we_i && size_i == SZ_W'(2)) ? OP_SEL : OP_BAD;
          end else if (off_i != '0 || size_i == '0 || int'(size_i) > MAX_W) begin
            op_o = OP_BAD;
          end else begin
            op_o = we_i ? OP_DROP : OP_READ;
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/cfg_item_rom.sv
module cfg_item_rom
  import cfg_item_pkg::*;
#(
  parameter int          MAX_W       = 8,
  parameter int          CUR_W       = 8,
  parameter logic [31:0] SIG         = 32'h4346_4750,
  parameter bit          DMA_PRESENT = 1'b1,
  parameter int          FILL_MOD    = 7,
  parameter int          TBL_SKEW    = 3,
  parameter logic [7:0]  TBL_XOR     = 8'h5A
) (
  input  logic                      tbl_i,
  input  logic [IDX_W-1:0]          idx_i,
  input  logic [CUR_W-1:0]          base_i,
  output logic [CUR_W-1:0]          len_o,
  output logic [MAX_W-1:0][7:0]     byte_o
);
  function automatic logic [CUR_W-1:0] item_len(logic tbl, logic [IDX_W-1:0] idx);
    if (!tbl && idx < IDX_W'(2)) return CUR_W'(4);
    return CUR_W'((int'(idx) + (tbl ? TBL_SKEW : 0)) % FILL_MOD);
  endfunction

  function automatic logic [7:0] item_byte(logic tbl, logic [IDX_W-1:0] idx,
                                           logic [CUR_W-1:0] off);
    if (!tbl && idx == '0) begin
      case (off)
        CUR_W'(0): return SIG[31:24];
        CUR_W'(1): return SIG[23:16];
        CUR_W'(2): return SIG[15:8];
        CUR_W'(3): return SIG[7:0];
        default:   return 8'h00;
      endcase
    end
    if (!tbl && idx == IDX_W'(1))
      return (off == '0) ? {6'b0, DMA_PRESENT, 1'b1} : 8'h00;
    return {idx[3:0], off[3:0]} ^ (tbl ? TBL_XOR : 8'h00);
  endfunction

  assign len_o = item_len(tbl_i, idx_i);

  for (genvar l = 0; l < MAX_W; l++) begin : g_lane
    assign byte_o[l] = item_byte(tbl_i, idx_i, base_i + CUR_W'(l));
  end
endmodule

// File: rtl/cfg_item_reader.sv
module cfg_item_reader
  import cfg_item_pkg::*;
#(
  parameter int MAX_W      = 8,
  parameter int SZ_W       = 4,
  parameter int CUR_W      = 8,
  parameter int FILE_FIRST = 32,
  parameter int FILE_SLOTS = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sel_wr_i,
  input  logic [KEY_W-1:0]      key_i,
  input  logic                  rd_i,
  input  logic [SZ_W-1:0]       size_i,
  input  logic [CUR_W-1:0]      len_i,
  input  logic [MAX_W-1:0][7:0] bytes_i,
  output logic                  tbl_o,
  output logic [IDX_W-1:0]      idx_o,
  output logic [CUR_W-1:0]      cur_o,
  output logic [CUR_W-1:0]      eff_len_o,
  output logic                  sel_ok_o,
  output logic [8*MAX_W-1:0]    data_o
);
  localparam int LIMIT = FILE_FIRST + FILE_SLOTS;

  logic             tbl_q, ok_q;
  logic [IDX_W-1:0] idx_q;
  logic [CUR_W-1:0] cur_q, avail, take;

  assign eff_len_o = ok_q ? len_i : '0;
  assign avail     = eff_len_o - cur_q;
  assign take      = (avail < CUR_W'(size_i)) ? avail : CUR_W'(size_i);

  always_comb begin
    data_o = '0;
    for (int l = 0; l < MAX_W; l++) begin
      if (CUR_W'(l) < take) data_o[(int'(size_i) - 1 - l)*8 +: 8] = bytes_i[l];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tbl_q <= 1'b0;
      idx_q <= '0;
      ok_q  <= 1'b1;
      cur_q <= '0;
    end else if (sel_wr_i) begin
      tbl_q <= key_i[TBL_BIT];
      idx_q <= key_i[IDX_W-1:0];
      ok_q  <= key_i[IDX_W-1:0] < IDX_W'(LIMIT);
      cur_q <= '0;
    end else if (rd_i) begin
      cur_q <= cur_q + take;
    end
  end

  assign tbl_o    = tbl_q;
  assign idx_o    = idx_q;
  assign cur_o    = cur_q;
  assign sel_ok_o = ok_q;
endmodule

// File: rtl/cfg_item_port.sv
module cfg_item_port
  import cfg_item_pkg::*;
#(
  parameter int          MAX_W       = 8,
  parameter int          OFF_W       = 3,
  parameter int          SZ_W        = 4,
  parameter int          CUR_W       = 8,
  parameter int          FILE_FIRST  = 32,
  parameter int          FILE_SLOTS  = 4,
  parameter logic [31:0] SIG         = 32'h4346_4750,
  parameter bit          DMA_PRESENT = 1'b1,
  parameter bit          COMBINED    = 1'b0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 acc_i,
  input  logic                 acc_we_i,
  input  logic                 acc_win_i,
  input  logic [OFF_W-1:0]     acc_off_i,
  input  logic [SZ_W-1:0]      acc_size_i,
  input  logic [KEY_W-1:0]     acc_wdata_i,
  output logic                 rsp_valid_o,
  output logic                 rsp_err_o,
  output logic [8*MAX_W-1:0]   rsp_data_o
);
  op_e                  op;
  logic                 sel_wr, rd_fire, sel_ok, tbl;
  logic [IDX_W-1:0]     idx;
  logic [CUR_W-1:0]     cur, cur_len, rom_len;
  logic [MAX_W-1:0][7:0] rom_bytes;
  logic [8*MAX_W-1:0]   rd_data;

  cfg_item_decode #(.MAX_W(MAX_W), .OFF_W(OFF_W), .SZ_W(SZ_W), .COMBINED(COMBINED)) u_dec (
    .acc_i(acc_i), .we_i(acc_we_i), .win_i(acc_win_i), .off_i(acc_off_i),
    .size_i(acc_size_i), .op_o(op)
  );

  assign sel_wr  = (op == OP_SEL);
  assign rd_fire = (op == OP_READ);

  cfg_item_reader #(.MAX_W(MAX_W), .SZ_W(SZ_W), .CUR_W(CUR_W),
                    .FILE_FIRST(FILE_FIRST), .FILE_SLOTS(FILE_SLOTS)) u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_wr_i(sel_wr), .key_i(acc_wdata_i),
    .rd_i(rd_fire), .size_i(acc_size_i), .len_i(rom_len), .bytes_i(rom_bytes),
    .tbl_o(tbl), .idx_o(idx), .cur_o(cur), .eff_len_o(cur_len),
    .sel_ok_o(sel_ok), .data_o(rd_data)
  );

  cfg_item_rom #(.MAX_W(MAX_W), .CUR_W(CUR_W), .SIG(SIG), .DMA_PRESENT(DMA_PRESENT)) u_rom (
    .tbl_i(tbl), .idx_i(idx), .base_i(cur), .len_o(rom_len), .byte_o(rom_bytes)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= acc_i;
      rsp_err_o   <= acc_i && (op == OP_BAD);
      rsp_data_o  <= (acc_i && rd_fire) ? rd_data : '0;
    end
  end
endmodule

// File: rtl/cfg_item_port_chk.sv
module cfg_item_port_chk #(
  parameter int MAX_W = 8,
  parameter int SZ_W  = 4,
  parameter int CUR_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               acc_i,
  input logic [SZ_W-1:0]    acc_size_i,
  input logic               rsp_valid_o,
  input logic               rsp_err_o,
  input logic [8*MAX_W-1:0] rsp_data_o,
  input logic               sel_wr,
  input logic               rd_fire,
  input logic               sel_ok,
  input logic [CUR_W-1:0]   cur,
  input logic [CUR_W-1:0]   cur_len
);
  logic [SZ_W-1:0] size_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) size_q <= '0;
    else         size_q <= acc_size_i;
  end

  a_r12_rsp_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> rsp_valid_o);
  a_r12_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i |=> !rsp_valid_o);
  a_r10_err_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_err_o) |-> rsp_data_o == '0);
  a_r2_rewind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_wr |=> cur == '0);
  a_r6_cursor_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur <= cur_len);
  a_r4_invalid_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fire && !sel_ok) |=> rsp_data_o == '0);
  a_r5_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_err_o) |-> (rsp_data_o >> {size_q, 3'b000}) == '0);
endmodule

bind cfg_item_port cfg_item_port_chk #(.MAX_W(MAX_W), .SZ_W(SZ_W), .CUR_W(CUR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(acc_i), .acc_size_i(acc_size_i),
  .rsp_valid_o(rsp_valid_o), .rsp_err_o(rsp_err_o), .rsp_data_o(rsp_data_o),
  .sel_wr(sel_wr), .rd_fire(rd_fire), .sel_ok(sel_ok), .cur(cur), .cur_len(cur_len)
);

// File: tb/sim_cfg_item_port.sv
module sim_cfg_item_port;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 36;

  typedef struct packed {
    logic        we;
    logic        win;
    logic [2:0]  off;
    logic [3:0]  size;
    logic [15:0] wd;
    logic        err;
    logic [63:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam logic [97:0] VECS [NV] = '{
    {1'b0,1'b1,3'd0,4'd4,16'h0000,1'b0,64'h43464750,8'd1},        // R1 signature
    {1'b0,1'b1,3'd0,4'd4,16'h0000,1'b0,64'h0,8'd6},               // R6 drained
    {1'b1,1'b0,3'd0,4'd2,16'h0000,1'b0,64'h0,8'd2},               // R2
    {1'b0,1'b1,3'd0,4'd2,16'h0000,1'b0,64'h4346,8'd5},            // R5
    {1'b0,1'b1,3'd0,4'd1,16'h0000,1'b0,64'h47,8'd5},              // R5
    {1'b1,1'b0,3'd0,4'd2,16'h0000,1'b0,64'h0,8'd2},               // R2 same key
    {1'b0,1'b1,3'd0,4'd1,16'h0000,1'b0,64'h43,8'd2},              // R2 rewound
    {1'b1,1'b0,3'd0,4'd2,16'h0001,1'b0,64'h0,8'd8},               // R8
    {1'b0,1'b1,3'd0,4'd4,16'h0000,1'b0,64'h03000000,8'd8},        // R8
    {1'b1,1'b0,3'd0,4'd2,16'h0005,1'b0,64'h0,8'd9},               // R9
    {1'b0,1'b1,3'd0,4'd8,16'h0000,1'b0,64'h5051525354000000,8'd5},// R5 R6
    {1'b0,1'b1,3'd0,4'd1,16'h0000,1'b0,64'h0,8'd6},               // R6
    {1'b1,1'b0,3'd0,4'd2,16'h0022,1'b0,64'h0,8'd9},               // R9
    {1'b0,1'b1,3'd0,4'd3,16'h0000,1'b0,64'h202122,8'd9},          // R9
    {1'b0,1'b1,3'd0,4'd2,16'h0000,1'b0,64'h2324,8'd9},            // R9
    {1'b0,1'b1,3'd0,4'd2,16'h0000,1'b0,64'h2500,8'd6},            // R6 pad
    {1'b1,1'b0,3'd0,4'd2,16'h4005,1'b0,64'h0,8'd3},               // R3 table 1
    {1'b0,1'b1,3'd0,4'd2,16'h0000,1'b0,64'h0A00,8'd3},            // R3
    {1'b1,1'b0,3'd0,4'd2,16'h8002,1'b0,64'h0,8'd3},               // R3 bit 15
    {1'b0,1'b1,3'd0,4'd2,16'h0000,1'b0,64'h2021,8'd3},            // R3
    {1'b1,1'b0,3'd0,4'd2,16'h0024,1'b0,64'h0,8'd4},               // R4 limit
    {1'b0,1'b1,3'd0,4'd4,16'h0000,1'b0,64'h0,8'd4},               // R4
    {1'b1,1'b0,3'd0,4'd2,16'h4023,1'b0,64'h0,8'd3},               // R3 last valid
    {1'b0,1'b1,3'd0,4'd4,16'h0000,1'b0,64'h6A6B6800,8'd3},        // R3
    {1'b1,1'b0,3'd0,4'd2,16'h0007,1'b0,64'h0,8'd7},               // R7
    {1'b0,1'b1,3'd0,4'd2,16'h0000,1'b0,64'h0,8'd7},               // R7
    {1'b1,1'b0,3'd0,4'd2,16'h0002,1'b0,64'h0,8'd10},              // R10
    {1'b0,1'b1,3'd1,4'd1,16'h0000,1'b1,64'h0,8'd10},              // R10 offset
    {1'b0,1'b1,3'd0,4'd1,16'h0000,1'b0,64'h20,8'd10},             // R10
    {1'b1,1'b1,3'd0,4'd1,16'h00FF,1'b0,64'h0,8'd10},              // R10 data write
    {1'b0,1'b1,3'd0,4'd1,16'h0000,1'b0,64'h21,8'd10},             // R10
    {1'b0,1'b0,3'd0,4'd2,16'h0000,1'b1,64'h0,8'd10},              // R10 selector read
    {1'b1,1'b0,3'd0,4'd1,16'h0000,1'b1,64'h0,8'd10},              // R10 narrow sel
    {1'b0,1'b1,3'd0,4'd1,16'h0000,1'b0,64'h0,8'd10},              // R10 not rewound
    {1'b0,1'b1,3'd0,4'd0,16'h0000,1'b1,64'h0,8'd10},              // R10 size 0
    {1'b0,1'b1,3'd0,4'd9,16'h0000,1'b1,64'h0,8'd10}               // R10 size 9
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        acc0 = 0, we0 = 0, win0 = 0;
  logic [2:0]  off0 = 0;
  logic [3:0]  size0 = 0;
  logic [15:0] wd0 = 0;
  logic        v0, e0;
  logic [63:0] d0;

  logic        acc1 = 0, we1 = 0, win1 = 0;
  logic [2:0]  off1 = 0;
  logic [3:0]  size1 = 0;
  logic [15:0] wd1 = 0;
  logic        v1, e1;
  logic [63:0] d1;

  cfg_item_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .acc_i(acc0), .acc_we_i(we0), .acc_win_i(win0),
    .acc_off_i(off0), .acc_size_i(size0), .acc_wdata_i(wd0),
    .rsp_valid_o(v0), .rsp_err_o(e0), .rsp_data_o(d0)
  );

  cfg_item_port #(.COMBINED(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .acc_i(acc1), .acc_we_i(we1), .acc_win_i(win1),
    .acc_off_i(off1), .acc_size_i(size1), .acc_wdata_i(wd1),
    .rsp_valid_o(v1), .rsp_err_o(e1), .rsp_data_o(d1)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(string req, logic [65:0] act, logic [65:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc_u0(logic we, logic win, logic [2:0] off, logic [3:0] size, logic [15:0] wd);
    @(negedge clk);
    acc0 = 1; we0 = we; win0 = win; off0 = off; size0 = size; wd0 = wd;
    @(negedge clk);
    acc0 = 0;
  endtask

  task automatic acc_u1(logic we, logic [3:0] size, logic [15:0] wd);
    @(negedge clk);
    acc1 = 1; we1 = we; win1 = 1'b0; off1 = 3'd3; size1 = size; wd1 = wd;
    @(negedge clk);
    acc1 = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 / reset state: idle outputs
    check("R12 reset idle", {v0, e0, d0}, {1'b0, 1'b0, 64'h0});
    check("R12 reset idle u1", {v1, e1, d1}, {1'b0, 1'b0, 64'h0});

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = vec_t'(VECS[i]);
      acc_u0(v.we, v.win, v.off, v.size, v.wd);
      check($sformatf("R%0d vec %0d", v.req, i), {v0, e0, d0}, {1'b1, v.err, v.exp});
    end
    @(negedge clk);
    check("R12 idle after access", {65'h0, v0}, 66'h0);

    // R11 combined decode
    acc_u1(1'b0, 4'd1, 16'h0);  check("R11 first byte", {v1, e1, d1}, {1'b1, 1'b0, 64'h43});
    acc_u1(1'b1, 4'd2, 16'h1);  check("R11 sel write",  {v1, e1, d1}, {1'b1, 1'b0, 64'h0});
    acc_u1(1'b0, 4'd1, 16'h0);  check("R11 version",    {v1, e1, d1}, {1'b1, 1'b0, 64'h03});
    acc_u1(1'b1, 4'd1, 16'hFF); check("R11 byte write", {v1, e1, d1}, {1'b1, 1'b0, 64'h0});
    acc_u1(1'b0, 4'd1, 16'h0);  check("R11 after write",{v1, e1, d1}, {1'b1, 1'b0, 64'h00});
    acc_u1(1'b0, 4'd2, 16'h0);  check("R11 wide read",  {v1, e1, d1}, {1'b1, 1'b1, 64'h0});
    acc_u1(1'b1, 4'd4, 16'h0);  check("R11 wide write", {v1, e1, d1}, {1'b1, 1'b1, 64'h0});
    acc_u1(1'b1, 4'd2, 16'h0);
    acc_u1(1'b0, 4'd1, 16'h0);  check("R11 reselect",   {v1, e1, d1}, {1'b1, 1'b0, 64'h43});

    // R1 reset mid-run
    acc_u0(1'b1, 1'b0, 3'd0, 4'd2, 16'h0005);
    acc_u0(1'b0, 1'b1, 3'd0, 4'd1, 16'h0);
    check("R9 pre-reset byte", {v0, e0, d0}, {1'b1, 1'b0, 64'h50});
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    acc_u0(1'b0, 1'b1, 3'd0, 4'd4, 16'h0);
    check("R1 after reset", {v0, e0, d0}, {1'b1, 1'b0, 64'h43464750});

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 5000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule